// File: doc/BRIEF.md
# Prioritized Interrupt Vector Acknowledge Controller

This block is the local interrupt controller of a single processor core. Each of 256 interrupt vectors has its own request line, and a rising edge on a line marks that vector pending. Software takes interrupts through a small register port. A read of the acknowledge register returns the most urgent vector that may be delivered and moves it from pending to in-service. A write to the end-of-interrupt register retires the most urgent in-service vector. A task-priority register holds off whole priority classes.

A vector's priority class is its upper four bits, and a larger vector number means higher priority. A candidate is deliverable only if its class is above both the class of the highest in-service vector and the task-priority class. Acknowledges can therefore nest: a handler that runs at class 3 can still be interrupted by class 5. When nothing is deliverable, the acknowledge read returns the fixed spurious vector 15 and leaves all state as it was. A registered interrupt-request output tells the core that something is deliverable, and a global enable input gates it.

Top module: `vecack_top`

## Requirements
- R1: A 0-to-1 transition on `reqIn[v]` marks vector v pending. A line that is held high does not mark it pending again.
- R2: A read of register 0 (acknowledge) returns, on `regRdData` in the cycle after the read strobe, the highest-numbered deliverable vector. The same edge moves that vector from pending to in-service.
- R3: Any vector whose class (bits 7:4) is less than or equal to the class of the highest in-service vector is held off. A vector of a higher class is still delivered, which lets acknowledges nest.
- R4: When no vector is deliverable, an acknowledge read returns 15 and changes neither pending nor in-service state.
- R5: A write to register 0x1 (end of interrupt; the data is ignored) retires the highest in-service vector. This releases the lower classes it was holding off.
- R6: An end-of-interrupt write while nothing is in service has no effect.
- R7: Register 0x2 (task priority) holds a class in bits 3:0 and reads back. Vectors whose class is less than or equal to it are held off, including the equal class. Lowering it makes held vectors deliverable.
- R8: `irqOut` rises one cycle after a vector becomes deliverable while `globalEn` is 1, and is 0 whenever `globalEn` was 0 in the previous cycle. Pending state is kept while delivery is gated off.
- R9: A new request for a vector that is in service stays pending and is delivered after that vector's end of interrupt.
- R10: After reset nothing is pending or in service, task priority is 0, `irqOut` is 0, and reads of register 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 256 | Per-vector request lines, edge sensitive |
| globalEn | input | 1 | Global delivery enable toward the core |
| regWrEn | input | 1 | Register write strobe; takes precedence over a read in the same cycle |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 acknowledge, 1 end of interrupt, 2 task priority |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, registered |
| irqOut | output | 1 | Interrupt request to the core, registered |

## Verification
A request edge becomes pending at the next clock edge. `irqOut` follows one edge after that, so the bench waits two falling edges after each stimulus before it samples the request output. Read data is registered once, so the bench sets a flag at the edge that takes a read, and the scoreboard monitor compares `regRdData` with the front of the expected queue at the following falling edge. Register writes, including task-priority changes and end-of-interrupt writes, act at one edge and reach `irqOut` at the next, and the same two-edge settle covers them.

// File: rtl/vecack_pkg.sv
package vecack_pkg;
  localparam int NUM_VEC_DEF = 256;
  localparam int CLASS_W_DEF = 4;
  localparam int SPUR_VEC_DEF = 15;

  typedef enum logic [1:0] {
    REG_ACK = 2'd0,
    REG_EOI = 2'd1,
    REG_TPR = 2'd2,
    REG_RSV = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ackTake;
    logic eoiDo;
  } ctlStrobe_t;
endpackage

// File: rtl/vecack_datapath.sv
module vecack_datapath
  import vecack_pkg::*;
#(
  parameter int NUM_VEC = NUM_VEC_DEF,
  parameter int CLASS_W = CLASS_W_DEF,
  localparam int VEC_W = $clog2(NUM_VEC),
  localparam int SUB_W = VEC_W - CLASS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  ctlStrobe_t         strobe,
  input  logic [CLASS_W-1:0] tprClass,
  output logic [VEC_W-1:0]   bestVec,
  output logic               bestValid,
  output logic               svcAny,
  output logic [NUM_VEC-1:0] svcVec
);
  logic [NUM_VEC-1:0] reqPrev;
  logic [NUM_VEC-1:0] pendVec;
  logic [NUM_VEC-1:0] risingEdge;
  logic [NUM_VEC-1:0] eligible;
  logic [VEC_W:0]     svcTop;
  logic [VEC_W:0]     bestTop;
  logic [CLASS_W-1:0] svcClass;
  logic [CLASS_W-1:0] floorClass;
  logic [NUM_VEC-1:0] ackMask;
  logic [NUM_VEC-1:0] eoiMask;

  function automatic logic [VEC_W:0] topIndex(input logic [NUM_VEC-1:0] bits);
    logic [VEC_W:0] found;
    found = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (bits[i]) found = {1'b1, VEC_W'(i)};
    end
    return found;
  endfunction

  assign risingEdge = reqIn & ~reqPrev;

  assign svcTop   = topIndex(svcVec);
  assign svcAny   = svcTop[VEC_W];
  assign svcClass = svcTop[VEC_W-1:SUB_W];

  always_comb begin
    floorClass = tprClass;
    if (svcAny && (svcClass > tprClass)) floorClass = svcClass;
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_elig
    localparam logic [CLASS_W-1:0] G_CLASS = CLASS_W'(g >> SUB_W);
    assign eligible[g] = pendVec[g] && (G_CLASS > floorClass);
  end

  assign bestTop   = topIndex(eligible);
  assign bestValid = bestTop[VEC_W];
  assign bestVec   = bestTop[VEC_W-1:0];

  always_comb begin
    ackMask = '0;
    eoiMask = '0;
    if (strobe.ackTake && bestValid) ackMask[bestVec] = 1'b1;
    if (strobe.eoiDo && svcAny) eoiMask[svcTop[VEC_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= '0;
      pendVec <= '0;
      svcVec  <= '0;
    end else begin
      reqPrev <= reqIn;
      pendVec <= (pendVec & ~ackMask) | risingEdge;
      svcVec  <= (svcVec & ~eoiMask) | ackMask;
    end
  end
endmodule

// File: rtl/vecack_ctrl.sv
module vecack_ctrl
  import vecack_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CLASS_W  = CLASS_W_DEF,
  parameter int SPUR_VEC = SPUR_VEC_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  input  logic [VEC_W-1:0]   bestVec,
  input  logic               bestValid,
  input  logic               svcAny,
  input  logic               globalEn,
  output ctlStrobe_t         strobe,
  output logic [CLASS_W-1:0] tprClass,
  output logic [VEC_W-1:0]   regRdData,
  output logic               irqOut
);
  localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);

  regSel_e sel;
  logic    rdGo;
  logic    wrGo;
  logic [VEC_W-1:0] rdNext;

  assign sel  = regSel_e'(regAddr);
  assign wrGo = regWrEn;
  assign rdGo = regRdEn && !regWrEn;

  always_comb begin
    strobe.ackTake = rdGo && (sel == REG_ACK) && bestValid;
    strobe.eoiDo   = wrGo && (sel == REG_EOI) && svcAny;
  end

  always_comb begin
    unique case (sel)
      REG_ACK: rdNext = bestValid ? bestVec : SPUR;
      REG_TPR: rdNext = VEC_W'(tprClass);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tprClass  <= '0;
      regRdData <= '0;
      irqOut    <= 1'b0;
    end else begin
      if (wrGo && (sel == REG_TPR)) tprClass <= regWrData[CLASS_W-1:0];
      if (rdGo) regRdData <= rdNext;
      irqOut <= bestValid && globalEn;
    end
  end
endmodule

// File: rtl/vecack_top.sv
module vecack_top
  import vecack_pkg::*;
#(
  parameter int NUM_VEC  = NUM_VEC_DEF,
  parameter int CLASS_W  = CLASS_W_DEF,
  parameter int SPUR_VEC = SPUR_VEC_DEF,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic               globalEn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  output logic [VEC_W-1:0]   regRdData,
  output logic               irqOut
);
  ctlStrobe_t         strobe;
  logic [CLASS_W-1:0] tprClass;
  logic [VEC_W-1:0]   bestVec;
  logic               bestValid;
  logic               svcAny;
  logic [NUM_VEC-1:0] svcVec;

  vecack_datapath #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strobe(strobe), .tprClass(tprClass),
    .bestVec(bestVec), .bestValid(bestValid), .svcAny(svcAny), .svcVec(svcVec)
  );

  vecack_ctrl #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .SPUR_VEC(SPUR_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .bestVec(bestVec), .bestValid(bestValid), .svcAny(svcAny),
    .globalEn(globalEn), .strobe(strobe), .tprClass(tprClass), .regRdData(regRdData),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/vecack_chk.sv
module vecack_chk #(
  parameter int NUM_VEC  = 256,
  parameter int CLASS_W  = 4,
  parameter int SPUR_VEC = 15,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               globalEn,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [1:0]         regAddr,
  input logic [VEC_W-1:0]   regRdData,
  input logic               irqOut,
  input logic [NUM_VEC-1:0] svcVec,
  input logic [VEC_W-1:0]   bestVec,
  input logic               bestValid,
  input logic [CLASS_W-1:0] tprClass
);
  logic ackRead;
  assign ackRead = regRdEn && !regWrEn && (regAddr == 2'd0);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irqOut);

  // R2
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && bestValid) |=> (svcVec[$past(bestVec)] && (regRdData == $past(bestVec))));

  // R4
  spur_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !bestValid) |=> (regRdData == VEC_W'(SPUR_VEC)));

  // R4
  spur_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !bestValid) |=> $stable(svcVec));

  // R6
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 2'd1) && (svcVec == '0)) |=> (svcVec == '0));

  // R7
  tpr_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && bestValid) |=> (regRdData[VEC_W-1 -: CLASS_W] > $past(tprClass)));

  // R3
  nest_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && bestValid) |=> ($countones(svcVec) == $countones($past(svcVec)) + 1));
endmodule

bind vecack_top vecack_chk #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk(clk), .rstN(rstN), .globalEn(globalEn), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .irqOut(irqOut), .svcVec(svcVec),
  .bestVec(bestVec), .bestValid(bestValid), .tprClass(tprClass)
);

// File: tb/vecack_top_bench.sv
module vecack_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_VEC-1:0] reqIn = '0;
  logic globalEn = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  logic rdSeen = 1'b0;
  logic finished = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  vecack_top u_vecack_top (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .globalEn(globalEn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rdSeen <= regRdEn && !regWrEn;

  // scoreboard monitor: compares read data one cycle after the read strobe
  always @(negedge clk) begin
    if (rdSeen) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %02h, expected nothing", regRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          errors++;
          $display("FAIL %s read actual=%02h expected=%02h", t, regRdData, e);
        end
      end
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int v);
    @(negedge clk) reqIn[v] = 1'b1;
    @(negedge clk) reqIn[v] = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    regAddr = a;
    regRdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk) regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", t, irqOut, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIrq(1'b0, "R10 reset");
    readReg(2'd2, 8'h00, "R10 tpr reset");
    readReg(2'd3, 8'h00, "R10 reserved reg");
    readReg(2'd0, 8'h0F, "R4 spurious after reset");
    globalEn = 1'b1;

    // basic delivery and nesting
    pulse(8'h35); settle();
    checkIrq(1'b1, "R1 edge pends");
    readReg(2'd0, 8'h35, "R2 ack 35");
    settle(); checkIrq(1'b0, "R3 own class held");
    pulse(8'h32); settle();
    checkIrq(1'b0, "R3 same class held");
    readReg(2'd0, 8'h0F, "R4 spurious while held");
    pulse(8'h51); settle();
    checkIrq(1'b1, "R3 higher class nests");
    readReg(2'd0, 8'h51, "R3 nested ack");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b0, "R5 outer still holds");
    readReg(2'd0, 8'h0F, "R5 outer still holds");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b1, "R5 release lower");
    readReg(2'd0, 8'h32, "R5 released vector");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b0, "R5 all retired");

    // idle end-of-interrupt, pending must survive
    writeReg(2'd2, 8'h02);
    pulse(8'h22);
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b0, "R6 idle eoi");
    writeReg(2'd2, 8'h01); settle();
    checkIrq(1'b1, "R6 pending kept");
    readReg(2'd0, 8'h22, "R6 pending kept");
    writeReg(2'd1, 8'h00);

    // task priority
    writeReg(2'd2, 8'h04);
    readReg(2'd2, 8'h04, "R7 readback");
    @(negedge clk) begin reqIn[8'h44] = 1'b1; reqIn[8'h41] = 1'b1; end
    @(negedge clk) begin reqIn[8'h44] = 1'b0; reqIn[8'h41] = 1'b0; end
    settle();
    checkIrq(1'b0, "R7 equal class held");
    readReg(2'd0, 8'h0F, "R7 equal class held");
    writeReg(2'd2, 8'h03); settle();
    checkIrq(1'b1, "R7 lowered");
    readReg(2'd0, 8'h44, "R7 lowered ack");
    writeReg(2'd1, 8'h00);
    readReg(2'd0, 8'h41, "R7 second ack");
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h00);

    // global enable
    globalEn = 1'b0;
    pulse(8'h90); settle();
    checkIrq(1'b0, "R8 gated");
    globalEn = 1'b1; settle();
    checkIrq(1'b1, "R8 ungated");
    readReg(2'd0, 8'h90, "R8 pending kept");
    writeReg(2'd1, 8'h00);

    // re-request of an in-service vector
    pulse(8'h70);
    readReg(2'd0, 8'h70, "R9 first ack");
    pulse(8'h70); settle();
    checkIrq(1'b0, "R9 held in service");
    readReg(2'd0, 8'h0F, "R9 held in service");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b1, "R9 redelivered");
    readReg(2'd0, 8'h70, "R9 second ack");
    writeReg(2'd1, 8'h00);

    // held level does not retrigger
    @(negedge clk) reqIn[8'h80] = 1'b1;
    settle();
    readReg(2'd0, 8'h80, "R1 level ack");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b0, "R1 level no retrigger");
    reqIn[8'h80] = 1'b0;

    // ordering among several pending
    @(negedge clk) begin reqIn[8'h61] = 1'b1; reqIn[8'hA2] = 1'b1; reqIn[8'h63] = 1'b1; end
    @(negedge clk) begin reqIn[8'h61] = 1'b0; reqIn[8'hA2] = 1'b0; reqIn[8'h63] = 1'b0; end
    readReg(2'd0, 8'hA2, "R2 highest first");
    writeReg(2'd1, 8'h00);
    readReg(2'd0, 8'h63, "R2 next highest");
    writeReg(2'd1, 8'h00);
    readReg(2'd0, 8'h61, "R2 last");
    writeReg(2'd1, 8'h00); settle();
    checkIrq(1'b0, "R5 drained");

    settle();
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard left %0d items, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule